// File: doc/BRIEF.md
# Clock Buffer Control Register Bank

This block is the control register bank of an eight-output differential clock buffer. A serial host engine, which is not part of this block, decodes bus transactions and presents them here as a plain register bus: an 8-bit address, 8-bit write data, a write strobe, a read strobe and 8-bit read data. The bank holds the per-output enables, the masks that let an output ignore a side-band disable request, the amplitude and slew selects, the input configuration bits and a block-read byte count. Its main product is a gated enable vector, one bit per output. A cleared bit means that output is driven to the low/low state.

Two write locks protect the control registers. One can only be released by the power-on reset. The other can be released by writing 1 to it again. A loss-of-signal (LOS) indication from the analog detector is synchronized with two flops. It then sets a sticky event flag that software clears by writing 1. While automatic output disable is enabled, the synchronized LOS also pulls every output enable low.

Top module: `clkbuf_regbank`

## Requirements
- R1: After reset the registers read as follows. 00h=EEh, 01h=24h, 04h=10h, 07h=07h, 08h=00h, 09h=00h, 11h=60h, 12h=09h (no LOS present), 14h=EEh, 15h=24h, 26h=00h, 27h=00h, 35h=00h, 62h=00h.
- R2: Only the defined bits of a register can be written, and every other bit reads 0. The writable bits are: 00h/08h/14h mask EEh, 01h/09h/15h mask 24h, 04h bit 4, 07h bits 4:0, 11h bits 7:4, 12h bits 7, 6 and 3, 35h bit 5, and 62h all bits.
- R3: An address outside the defined set reads 00h, and a write to it changes nothing.
- R4: Output n is enabled by a fixed bit position. In 00h, outputs 2 to 7 use bits 7, 6, 5, 3, 2 and 1. In 01h, output 0 uses bit 5 and output 1 uses bit 2. A 0 in that bit drives out_en[n] low.
- R5: When sb_disable[n] is high, out_en[n] is forced low. The exception is when the mask bit for output n is set, at the same position in 08h/09h as its enable bit in 00h/01h.
- R6: When bit 4 of 04h is 1 and the synchronized LOS is active, every out_en bit is 0. The synchronized LOS follows los_raw after two clock edges. When bit 4 is 0, LOS has no effect on out_en.
- R7: Bit 1 of 27h is a sticky LOS event flag. Synchronized LOS sets it. Writing 1 to it clears it, but if LOS is still active in that cycle, the set wins.
- R8: Bit 0 of 12h reads the synchronized LOS inverted: 0 means loss is present.
- R9: Writing 1 to bit 0 of 26h sets a permanent lock. The lock blocks writes to every register except 27h, and only rst_n clears it.
- R10: Writing 1 to bit 0 of 27h toggles a releasable lock, and writing 0 leaves it unchanged. While this lock is set, writes to every register except 27h are blocked.
- R11: bus_rdata is loaded on the clock edge where bus_rd is high, so it appears one cycle after the read strobe. It holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| los_raw | input | 1 | Asynchronous loss-of-signal indication, high means loss |
| sb_disable | input | 8 | Per-output side-band disable requests |
| out_en | output | 8 | Gated per-output enables, 0 means low/low |

## Verification
A wrong lock state shows up as a register that fails to update, or updates when it should not. A read of the same address on the next cycle exposes it, with the read data appearing one cycle after the strobe. A wrong synchronizer or AOD state shows up on out_en. This happens exactly two edges after los_raw changes, and the sticky flag changes one edge after that. The bench samples out_en and the 27h read at those points. A corrupted mask or enable bit at a given position shows up on a single out_en bit as soon as the write completes, so the bench varies bit patterns and watches individual outputs.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned N_OUT   = 8;
    localparam int unsigned SYNC_N  = 2;
    localparam int unsigned BC_W    = 5;
    localparam int unsigned AMP_W   = 4;

    localparam logic [ADDR_W-1:0] A_ENA_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENA_LO  = 8'h01;
    localparam logic [ADDR_W-1:0] A_AOD     = 8'h04;
    localparam logic [ADDR_W-1:0] A_BCNT    = 8'h07;
    localparam logic [ADDR_W-1:0] A_MSK_HI  = 8'h08;
    localparam logic [ADDR_W-1:0] A_MSK_LO  = 8'h09;
    localparam logic [ADDR_W-1:0] A_AMP     = 8'h11;
    localparam logic [ADDR_W-1:0] A_INCFG   = 8'h12;
    localparam logic [ADDR_W-1:0] A_SLM_HI  = 8'h14;
    localparam logic [ADDR_W-1:0] A_SLM_LO  = 8'h15;
    localparam logic [ADDR_W-1:0] A_PLOCK   = 8'h26;
    localparam logic [ADDR_W-1:0] A_STAT    = 8'h27;
    localparam logic [ADDR_W-1:0] A_SLMODE  = 8'h35;
    localparam logic [ADDR_W-1:0] A_SLL     = 8'h62;

    localparam logic [REG_W-1:0] MASK_HI = 8'hEE;
    localparam logic [REG_W-1:0] MASK_LO = 8'h24;

    localparam int unsigned AOD_BIT    = 4;
    localparam int unsigned SLMODE_BIT = 5;
    localparam int unsigned LOCK_BIT   = 0;
    localparam int unsigned EVT_BIT    = 1;

    typedef struct packed {
        logic [REG_W-1:0] ena_hi;
        logic [REG_W-1:0] ena_lo;
        logic             aod;
        logic [BC_W-1:0]  bcnt;
        logic [REG_W-1:0] msk_hi;
        logic [REG_W-1:0] msk_lo;
        logic [AMP_W-1:0] amp;
        logic             in_ac;
        logic             in_term;
        logic             pd_keep;
        logic [REG_W-1:0] slm_hi;
        logic [REG_W-1:0] slm_lo;
        logic [REG_W-1:0] sll;
        logic             sl_mode;
        logic             perm_lock;
        logic             rel_lock;
        logic             los_evt;
        logic [REG_W-1:0] rdata;
    } bank_t;

    // Bit position of output n within its enable or mask register
    function automatic int unsigned out_pos(int unsigned n);
        case (n)
            0:       return 5;
            1:       return 2;
            2:       return 7;
            3:       return 6;
            4:       return 5;
            5:       return 3;
            6:       return 2;
            default: return 1;
        endcase
    endfunction

    // Outputs 0 and 1 sit in the low register of each pair
    function automatic bit out_in_lo(int unsigned n);
        return n < 2;
    endfunction

    function automatic bit addr_defined(logic [ADDR_W-1:0] a);
        case (a)
            A_ENA_HI, A_ENA_LO, A_AOD, A_BCNT, A_MSK_HI, A_MSK_LO,
            A_AMP, A_INCFG, A_SLM_HI, A_SLM_LO, A_PLOCK, A_STAT,
            A_SLMODE, A_SLL: return 1'b1;
            default:         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clkbuf_los_sync.sv
module clkbuf_los_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkbuf_regfile.sv
module clkbuf_regfile
    import clkbuf_pkg::*;
#(
    parameter int unsigned NOUT = N_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              los_s,
    output logic [REG_W-1:0]  rdata,
    output logic [NOUT-1:0]   en_vec,
    output logic [NOUT-1:0]   msk_vec,
    output logic              aod_kill,
    output logic              perm_lock,
    output logic              any_lock,
    output logic              los_evt
);
    bank_t r_d, r_q;
    logic  open_d;
    logic  evt_clr;
    logic [REG_W-1:0] rd_mux;

    localparam bank_t RESET_VAL = '{
        ena_hi:    MASK_HI,
        ena_lo:    MASK_LO,
        aod:       1'b1,
        bcnt:      BC_W'(7),
        msk_hi:    '0,
        msk_lo:    '0,
        amp:       AMP_W'(6),
        in_ac:     1'b0,
        in_term:   1'b0,
        pd_keep:   1'b1,
        slm_hi:    MASK_HI,
        slm_lo:    MASK_LO,
        sll:       '0,
        sl_mode:   1'b0,
        perm_lock: 1'b0,
        rel_lock:  1'b0,
        los_evt:   1'b0,
        rdata:     '0
    };

    // Read multiplexer, reserved locations and bits return zero
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_ENA_HI: rd_mux = r_q.ena_hi;
            A_ENA_LO: rd_mux = r_q.ena_lo;
            A_AOD:    rd_mux[AOD_BIT] = r_q.aod;
            A_BCNT:   rd_mux[BC_W-1:0] = r_q.bcnt;
            A_MSK_HI: rd_mux = r_q.msk_hi;
            A_MSK_LO: rd_mux = r_q.msk_lo;
            A_AMP:    rd_mux[REG_W-1:REG_W-AMP_W] = r_q.amp;
            A_INCFG:  rd_mux = {r_q.in_ac, r_q.in_term, 2'b00,
                                r_q.pd_keep, 2'b00, ~los_s};
            A_SLM_HI: rd_mux = r_q.slm_hi;
            A_SLM_LO: rd_mux = r_q.slm_lo;
            A_PLOCK:  rd_mux[LOCK_BIT] = r_q.perm_lock;
            A_STAT: begin
                rd_mux[LOCK_BIT] = r_q.rel_lock;
                rd_mux[EVT_BIT]  = r_q.los_evt;
            end
            A_SLMODE: rd_mux[SLMODE_BIT] = r_q.sl_mode;
            A_SLL:    rd_mux = r_q.sll;
            default:  rd_mux = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d     = r_q;
        open_d  = !(r_q.perm_lock || r_q.rel_lock);
        evt_clr = 1'b0;

        if (wr) begin
            if (addr == A_STAT) begin
                if (wdata[LOCK_BIT]) r_d.rel_lock = ~r_q.rel_lock;
                evt_clr = wdata[EVT_BIT];
            end else if (open_d) begin
                case (addr)
                    A_ENA_HI: r_d.ena_hi = wdata & MASK_HI;
                    A_ENA_LO: r_d.ena_lo = wdata & MASK_LO;
                    A_AOD:    r_d.aod    = wdata[AOD_BIT];
                    A_BCNT:   r_d.bcnt   = wdata[BC_W-1:0];
                    A_MSK_HI: r_d.msk_hi = wdata & MASK_HI;
                    A_MSK_LO: r_d.msk_lo = wdata & MASK_LO;
                    A_AMP:    r_d.amp    = wdata[REG_W-1:REG_W-AMP_W];
                    A_INCFG: begin
                        r_d.in_ac   = wdata[7];
                        r_d.in_term = wdata[6];
                        r_d.pd_keep = wdata[3];
                    end
                    A_SLM_HI: r_d.slm_hi = wdata & MASK_HI;
                    A_SLM_LO: r_d.slm_lo = wdata & MASK_LO;
                    A_PLOCK:  if (wdata[LOCK_BIT]) r_d.perm_lock = 1'b1;
                    A_SLMODE: r_d.sl_mode = wdata[SLMODE_BIT];
                    A_SLL:    r_d.sll     = wdata;
                    default:  ;
                endcase
            end
        end

        // Hardware set has priority over a software clear
        r_d.los_evt = los_s || (r_q.los_evt && !evt_clr);

        if (rd) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    // Collect enable and mask bits per output from their fixed positions
    for (genvar n = 0; n < NOUT; n++) begin : g_out
        if (out_in_lo(n)) begin : g_lo
            assign en_vec[n]  = r_q.ena_lo[out_pos(n)];
            assign msk_vec[n] = r_q.msk_lo[out_pos(n)];
        end else begin : g_hi
            assign en_vec[n]  = r_q.ena_hi[out_pos(n)];
            assign msk_vec[n] = r_q.msk_hi[out_pos(n)];
        end
    end

    assign rdata     = r_q.rdata;
    assign aod_kill  = r_q.aod && los_s;
    assign perm_lock = r_q.perm_lock;
    assign any_lock  = r_q.perm_lock || r_q.rel_lock;
    assign los_evt   = r_q.los_evt;
endmodule

// File: rtl/clkbuf_gate.sv
module clkbuf_gate #(
    parameter int unsigned NOUT = 8
) (
    input  logic [NOUT-1:0] en_vec,
    input  logic [NOUT-1:0] msk_vec,
    input  logic [NOUT-1:0] sb_dis,
    input  logic            kill_all,
    output logic [NOUT-1:0] gated
);
    for (genvar n = 0; n < NOUT; n++) begin : g_gate
        logic sb_hit;
        assign sb_hit   = sb_dis[n] && !msk_vec[n];
        assign gated[n] = en_vec[n] && !sb_hit && !kill_all;
    end
endmodule

// File: rtl/clkbuf_regbank.sv
module clkbuf_regbank
    import clkbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              los_raw,
    input  logic [N_OUT-1:0]  sb_disable,
    output logic [N_OUT-1:0]  out_en
);
    logic             los_s;
    logic [N_OUT-1:0] en_vec;
    logic [N_OUT-1:0] msk_vec;
    logic             aod_kill;
    logic             perm_lock;
    logic             any_lock;
    logic             los_evt;

    clkbuf_los_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (los_raw),
        .q_sync  (los_s)
    );

    clkbuf_regfile #(.NOUT(N_OUT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .los_s     (los_s),
        .rdata     (bus_rdata),
        .en_vec    (en_vec),
        .msk_vec   (msk_vec),
        .aod_kill  (aod_kill),
        .perm_lock (perm_lock),
        .any_lock  (any_lock),
        .los_evt   (los_evt)
    );

    clkbuf_gate #(.NOUT(N_OUT)) u_gate (
        .en_vec   (en_vec),
        .msk_vec  (msk_vec),
        .sb_dis   (sb_disable),
        .kill_all (aod_kill),
        .gated    (out_en)
    );
endmodule

// File: rtl/clkbuf_regbank_chk.sv
module clkbuf_regbank_chk
    import clkbuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [N_OUT-1:0]  out_en,
    input logic [N_OUT-1:0]  en_vec,
    input logic              aod_kill,
    input logic              perm_lock,
    input logic              any_lock,
    input logic              los_s,
    input logic              los_evt
);
    assert_aod_all_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        aod_kill |-> (out_en == '0));

    assert_perm_lock_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        perm_lock |=> perm_lock);

    assert_locked_enables_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_lock && bus_wr && bus_addr != A_STAT) |=> $stable(en_vec));

    assert_los_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        los_s |=> los_evt);

    assert_reserved_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !addr_defined(bus_addr)) |=> (bus_rdata == '0));

    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind clkbuf_regbank clkbuf_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .out_en    (out_en),
    .en_vec    (en_vec),
    .aod_kill  (aod_kill),
    .perm_lock (perm_lock),
    .any_lock  (any_lock),
    .los_s     (los_s),
    .los_evt   (los_evt)
);

// File: tb/clkbuf_regbank_test.sv
module clkbuf_regbank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       los_raw = 1'b0;
    logic [7:0] sb_disable = '0;
    logic [7:0] out_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkbuf_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .los_raw(los_raw), .sb_disable(sb_disable), .out_en(out_en)
    );

    typedef struct packed {
        logic       is_rd;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 8'hEE, 8'd1},  // R1
        '{1'b1, 8'h01, 8'h24, 8'd1},  // R1
        '{1'b1, 8'h04, 8'h10, 8'd1},  // R1
        '{1'b1, 8'h07, 8'h07, 8'd1},  // R1
        '{1'b1, 8'h09, 8'h00, 8'd1},  // R1
        '{1'b1, 8'h11, 8'h60, 8'd1},  // R1
        '{1'b1, 8'h12, 8'h09, 8'd1},  // R1, R8
        '{1'b1, 8'h15, 8'h24, 8'd1},  // R1
        '{1'b1, 8'h27, 8'h00, 8'd1},  // R1
        '{1'b0, 8'h14, 8'hFF, 8'd2},  // R2
        '{1'b1, 8'h14, 8'hEE, 8'd2},
        '{1'b0, 8'h07, 8'hFF, 8'd2},
        '{1'b1, 8'h07, 8'h1F, 8'd2},
        '{1'b0, 8'h11, 8'hA5, 8'd2},
        '{1'b1, 8'h11, 8'hA0, 8'd2},
        '{1'b0, 8'h35, 8'hFF, 8'd2},
        '{1'b1, 8'h35, 8'h20, 8'd2},
        '{1'b0, 8'h62, 8'h5A, 8'd2},
        '{1'b1, 8'h62, 8'h5A, 8'd2},
        '{1'b0, 8'h0A, 8'h55, 8'd3},  // R3
        '{1'b1, 8'h0A, 8'h00, 8'd3},
        '{1'b1, 8'h05, 8'h00, 8'd3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        do_reset();
        check("R4 reset out_en", out_en, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) rd(VEC[i].a, VEC[i].d, $sformatf("R%0d vec%0d", VEC[i].req, i));
            else              wr(VEC[i].a, VEC[i].d);
        end

        // R4 enable bit positions
        wr(8'h00, 8'h00);
        check("R4 hi cleared", out_en, 8'h03);
        wr(8'h01, 8'h04);
        check("R4 only out1", out_en, 8'h02);
        wr(8'h00, 8'h80);
        wr(8'h01, 8'h20);
        check("R4 out2 and out0", out_en, 8'h05);
        wr(8'h00, 8'hEE);
        wr(8'h01, 8'h24);

        // R5 side-band disable with masks
        sb_disable = 8'hF0;
        idle(1);
        check("R5 unmasked", out_en, 8'h0F);
        wr(8'h08, 8'h22);
        check("R5 masked out4 out7", out_en, 8'h9F);
        sb_disable = 8'h00;
        wr(8'h08, 8'h00);

        // R6, R7, R8 LOS handling
        @(negedge clk); los_raw = 1'b1;
        @(negedge clk);
        check("R6 one edge no effect", out_en, 8'hFF);
        @(negedge clk);
        check("R6 aod forces low", out_en, 8'h00);
        rd(8'h12, 8'h08, "R8 live los");
        rd(8'h27, 8'h02, "R7 flag set");
        wr(8'h27, 8'h02);
        rd(8'h27, 8'h02, "R7 set wins");
        @(negedge clk); los_raw = 1'b0;
        idle(3);
        check("R6 restore", out_en, 8'hFF);
        rd(8'h27, 8'h02, "R7 sticky");
        wr(8'h27, 8'h02);
        rd(8'h27, 8'h00, "R7 w1c");
        rd(8'h12, 8'h09, "R8 no los");
        wr(8'h04, 8'h00);
        @(negedge clk); los_raw = 1'b1;
        idle(3);
        check("R6 aod off", out_en, 8'hFF);
        rd(8'h27, 8'h02, "R7 flag with aod off");
        @(negedge clk); los_raw = 1'b0;
        idle(3);
        wr(8'h27, 8'h02);
        wr(8'h04, 8'h10);

        // R10 releasable lock
        wr(8'h27, 8'h01);
        rd(8'h27, 8'h01, "R10 lock set");
        wr(8'h00, 8'h00);
        rd(8'h00, 8'hEE, "R10 blocked");
        check("R10 out_en unchanged", out_en, 8'hFF);
        wr(8'h27, 8'h00);
        rd(8'h27, 8'h01, "R10 write0 ignored");
        wr(8'h27, 8'h01);
        rd(8'h27, 8'h00, "R10 released");
        wr(8'h00, 8'h0E);
        rd(8'h00, 8'h0E, "R10 writable again");
        wr(8'h00, 8'hEE);

        // R11 read data holds without strobe
        rd(8'h07, 8'h1F, "R11 read");
        @(negedge clk); bus_addr = 8'h00;
        idle(2);
        check("R11 hold", bus_rdata, 8'h1F);

        // R9 permanent lock
        wr(8'h26, 8'h01);
        rd(8'h26, 8'h01, "R9 set");
        wr(8'h00, 8'h00);
        rd(8'h00, 8'hEE, "R9 blocked");
        wr(8'h26, 8'h00);
        rd(8'h26, 8'h01, "R9 not cleared by write");
        wr(8'h27, 8'h01);
        rd(8'h27, 8'h01, "R9 status still writable");
        wr(8'h27, 8'h01);
        rd(8'h27, 8'h00, "R9 status toggle");
        wr(8'h07, 8'h03);
        rd(8'h07, 8'h1F, "R9 bcnt blocked");
        do_reset();
        rd(8'h26, 8'h00, "R9 reset clears");
        rd(8'h07, 8'h07, "R1 reset after lock");
        wr(8'h00, 8'h00);
        rd(8'h00, 8'h00, "R9 writable after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule